// File: doc/BRIEF.md
# Level-Following Interrupt Combiner for a Real-Time Clock

This block merges the event flags of a real-time clock into one active-low interrupt line. There are three kinds of source: a bank of capture flags (one per capture channel), a supply change-over flag, and a low-supply flag. Each source kind has its own enable bit. The line is low whenever any enabled source has its flag set, and high otherwise. The line follows flag levels only and never emits a pulse.

The capture flags and the change-over flag are set by single-cycle event strobes. Software clears them by writing 0 to their bits through a small synchronous register port. The low-supply flag cannot be cleared by software. It mirrors an external condition input, one clock later, and returns to 0 only when that condition ends. Its interrupt can also be removed by clearing its enable bit.

The register port has two registers, chosen by a one-bit select. Reads are combinational from the select input. Writes take effect on the clock edge. The read-only flag has no lane in the write data.

Top module: `irqf_top`

## Requirements
- R1: After a synchronous active-high reset, all flags and all enable bits are 0 and `irq_n` is 1.
- R2: A 1 on bit i of `cap_evt` sets capture flag i. The flag reads back as 1 in flag-register bit i from the clock edge that samples the strobe.
- R3: While the capture enable (enable-register bit 0) is 1, `irq_n` is low whenever at least one capture flag is 1.
- R4: A write to the flag register (`sel`=1) clears each capture flag whose `wdata` bit is 0 and leaves alone each flag whose `wdata` bit is 1. `irq_n` follows at the same edge.
- R5: When an event strobe and a clearing write reach the same flag in one cycle, the flag ends up set.
- R6: `chg_evt` sets the change-over flag, which reads back in flag-register bit NUM_TS. A write with `wdata` bit NUM_TS at 0 clears it. While enable bit 1 is set, `irq_n` follows this flag.
- R7: The low-supply flag (flag-register bit NUM_TS+1) equals the value `low_cond` had one cycle earlier. Writes to the register port never change it.
- R8: While enable bit 2 is 1, `irq_n` is low when the low-supply flag is 1. The interrupt goes away when the flag drops or when enable bit 2 is cleared.
- R9: `irq_n` is purely level-following. It stays constant while flags and enables are constant, and a flag whose enable is 0 has no effect on it.
- R10: A read of the enable register (`sel`=0) returns the enable bits in positions 2..0 and 0 in all higher positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_evt | input | NUM_TS | Single-cycle set strobes for the capture flags |
| chg_evt | input | 1 | Single-cycle set strobe for the change-over flag |
| low_cond | input | 1 | Low-supply condition level |
| wr_en | input | 1 | Register write strobe |
| sel | input | 1 | Register select: 0 enables, 1 flags |
| wdata | input | max(3, NUM_TS+1) | Write data |
| rdata | output | max(3, NUM_TS+2) | Read data for the selected register |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
A strobe, a register write or a change of the low-supply condition is sampled at one clock edge. The flags, and therefore `irq_n`, show the result right after that same edge. No other register lies on the path, so every result is due exactly one edge after its stimulus is applied. The bench drives inputs at the falling edge and reads `rdata` and `irq_n` at the next falling edge, so each check lands half a period after the edge that produced the result. Hold checks repeat the sample over several further edges to show that nothing pulses.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int EN_W = 3;

    typedef enum logic {
        SEL_EN   = 1'b0,
        SEL_FLAG = 1'b1
    } sel_e;

    // bit 0: capture, bit 1: change-over, bit 2: low-supply
    typedef struct packed {
        logic low;
        logic chg;
        logic cap;
    } en_t;

    typedef struct packed {
        logic cap_any;
        logic chg;
        logic low;
    } src_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic en_t en_unpack(input logic [EN_W-1:0] w);
        en_t e;
        e.cap = w[0];
        e.chg = w[1];
        e.low = w[2];
        return e;
    endfunction

endpackage

// File: rtl/irqf_en_reg.sv
module irqf_en_reg
    import irqf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_stb,
    input  logic [EN_W-1:0] wbits,
    output en_t             en
);

    en_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_stb) begin
            en_q <= en_unpack(wbits);
        end
    end

    assign en = en_q;

endmodule

// File: rtl/irqf_flags.sv
module irqf_flags #(
    parameter int NUM_TS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_TS-1:0] cap_evt,
    input  logic              chg_evt,
    input  logic              low_cond,
    input  logic              clr_stb,
    input  logic [NUM_TS:0]   keep,
    output logic [NUM_TS-1:0] cap_flags,
    output logic              chg_flag,
    output logic              low_flag
);

    for (genvar i = 0; i < NUM_TS; i++) begin : g_cap
        logic q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else if (cap_evt[i]) begin
                q <= 1'b1;
            end else if (clr_stb && !keep[i]) begin
                q <= 1'b0;
            end
        end
        assign cap_flags[i] = q;
    end

    logic chg_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chg_q <= 1'b0;
        end else if (chg_evt) begin
            chg_q <= 1'b1;
        end else if (clr_stb && !keep[NUM_TS]) begin
            chg_q <= 1'b0;
        end
    end

    // read-only: tracks the condition, no write path
    logic low_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= 1'b0;
        end else begin
            low_q <= low_cond;
        end
    end

    assign chg_flag = chg_q;
    assign low_flag = low_q;

endmodule

// File: rtl/irqf_combine.sv
module irqf_combine
    import irqf_pkg::*;
#(
    parameter int NUM_TS = 2
) (
    input  logic [NUM_TS-1:0] cap_flags,
    input  logic              chg_flag,
    input  logic              low_flag,
    input  en_t               en,
    output logic              irq_n
);

    src_t src;

    always_comb begin
        src.cap_any = en.cap & (|cap_flags);
        src.chg     = en.chg & chg_flag;
        src.low     = en.low & low_flag;
        irq_n       = ~(|src);
    end

endmodule

// File: rtl/irqf_top.sv
module irqf_top
    import irqf_pkg::*;
#(
    parameter  int NUM_TS = 2,
    localparam int WR_W   = imax(EN_W, NUM_TS + 1),
    localparam int RD_W   = imax(EN_W, NUM_TS + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_TS-1:0] cap_evt,
    input  logic              chg_evt,
    input  logic              low_cond,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [WR_W-1:0]   wdata,
    output logic [RD_W-1:0]   rdata,
    output logic              irq_n
);

    en_t               en;
    logic [NUM_TS-1:0] cap_flags;
    logic              chg_flag;
    logic              low_flag;
    logic              en_wr;
    logic              flag_wr;

    assign en_wr   = wr_en && (sel == SEL_EN);
    assign flag_wr = wr_en && (sel == SEL_FLAG);

    irqf_en_reg u_en (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (en_wr),
        .wbits  (wdata[EN_W-1:0]),
        .en     (en)
    );

    irqf_flags #(.NUM_TS(NUM_TS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .cap_evt   (cap_evt),
        .chg_evt   (chg_evt),
        .low_cond  (low_cond),
        .clr_stb   (flag_wr),
        .keep      (wdata[NUM_TS:0]),
        .cap_flags (cap_flags),
        .chg_flag  (chg_flag),
        .low_flag  (low_flag)
    );

    irqf_combine #(.NUM_TS(NUM_TS)) u_comb (
        .cap_flags (cap_flags),
        .chg_flag  (chg_flag),
        .low_flag  (low_flag),
        .en        (en),
        .irq_n     (irq_n)
    );

    always_comb begin
        if (sel == SEL_FLAG) begin
            rdata = RD_W'({low_flag, chg_flag, cap_flags});
        end else begin
            rdata = RD_W'({en.low, en.chg, en.cap});
        end
    end

endmodule

// File: rtl/irqf_chk.sv
module irqf_chk
    import irqf_pkg::*;
#(
    parameter int NUM_TS = 2,
    parameter int WR_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_TS-1:0] cap_evt,
    input logic              chg_evt,
    input logic              low_cond,
    input logic              wr_en,
    input logic              sel,
    input logic [WR_W-1:0]   wdata,
    input logic [NUM_TS-1:0] cap_flags,
    input logic              chg_flag,
    input logic              low_flag,
    input en_t               en,
    input logic              irq_n
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_n);

    p_cap_set_r2: assert property (@(posedge clk) disable iff (rst)
        (cap_evt != '0) |=> ((cap_flags & $past(cap_evt)) == $past(cap_evt)));

    p_cap_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_FLAG) |=>
        ((cap_flags & ~$past(wdata[NUM_TS-1:0]) & ~$past(cap_evt)) == '0));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (chg_evt && wr_en && sel == SEL_FLAG) |=> chg_flag);

    p_chg_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_FLAG && !wdata[NUM_TS] && !chg_evt) |=> !chg_flag);

    p_low_follow_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (low_flag == $past(low_cond)));

    p_low_release_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(low_flag) && !en.cap && !en.chg) |-> irq_n);

    p_level_only_r9: assert property (@(posedge clk) disable iff (rst)
        ($stable(en) && $stable(cap_flags) && $stable(chg_flag) && $stable(low_flag))
        |-> $stable(irq_n));

endmodule

bind irqf_top irqf_chk #(.NUM_TS(NUM_TS), .WR_W(WR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cap_evt   (cap_evt),
    .chg_evt   (chg_evt),
    .low_cond  (low_cond),
    .wr_en     (wr_en),
    .sel       (sel),
    .wdata     (wdata),
    .cap_flags (cap_flags),
    .chg_flag  (chg_flag),
    .low_flag  (low_flag),
    .en        (en),
    .irq_n     (irq_n)
);

// File: tb/test_irqf_top.sv
module test_irqf_top;

    localparam int NUM_TS = 2;
    localparam int WR_W   = 3;
    localparam int RD_W   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_TS-1:0] cap_evt = '0;
    logic              chg_evt = 1'b0;
    logic              low_cond = 1'b0;
    logic              wr_en = 1'b0;
    logic              sel = 1'b0;
    logic [WR_W-1:0]   wdata = '0;
    logic [RD_W-1:0]   rdata;
    logic              irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqf_top #(.NUM_TS(NUM_TS)) i_irqf_top (
        .clk      (clk),
        .rst      (rst),
        .cap_evt  (cap_evt),
        .chg_evt  (chg_evt),
        .low_cond (low_cond),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (wdata),
        .rdata    (rdata),
        .irq_n    (irq_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [WR_W-1:0] d);
        wr_en = 1'b1;
        sel   = s;
        wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [RD_W-1:0] d);
        sel = s;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [RD_W-1:0] d;
        check("R1 irq_n after reset", 8'(irq_n), 8'h1);
        rd(1'b1, d);
        check("R1 flags after reset", 8'(d), 8'h0);
        rd(1'b0, d);
        check("R1 enables after reset", 8'(d), 8'h0);
    endtask

    task automatic t_readback();
        logic [RD_W-1:0] d;
        wr(1'b0, 3'b101);
        rd(1'b0, d);
        check("R10 enable readback", 8'(d), 8'h5);
        wr(1'b0, 3'b000);
        rd(1'b0, d);
        check("R10 enable cleared", 8'(d), 8'h0);
    endtask

    task automatic t_capture();
        logic [RD_W-1:0] d;
        cap_evt = 2'b10;
        tick();
        cap_evt = '0;
        rd(1'b1, d);
        check("R2 capture flag 1 set", 8'(d), 8'h2);
        check("R9 disabled flag keeps irq high", 8'(irq_n), 8'h1);
        wr(1'b0, 3'b001);
        check("R3 irq low once enabled", 8'(irq_n), 8'h0);
        for (int k = 0; k < 4; k++) tick();
        check("R9 irq stays low (no pulse)", 8'(irq_n), 8'h0);
        wr(1'b1, 3'b111);
        rd(1'b1, d);
        check("R4 writing ones keeps flags", 8'(d), 8'h2);
        wr(1'b1, 3'b101);
        rd(1'b1, d);
        check("R4 flag cleared by zero", 8'(d), 8'h0);
        check("R4 irq released at clear", 8'(irq_n), 8'h1);
    endtask

    task automatic t_set_wins();
        logic [RD_W-1:0] d;
        cap_evt = 2'b01;
        wr(1'b1, 3'b000);
        cap_evt = '0;
        rd(1'b1, d);
        check("R5 set beats clear", 8'(d), 8'h1);
        check("R5 irq low after set", 8'(irq_n), 8'h0);
        wr(1'b1, 3'b000);
        check("R4 irq high after later clear", 8'(irq_n), 8'h1);
    endtask

    task automatic t_changeover();
        logic [RD_W-1:0] d;
        wr(1'b0, 3'b010);
        chg_evt = 1'b1;
        tick();
        chg_evt = 1'b0;
        rd(1'b1, d);
        check("R6 change-over flag bit", 8'(d), 8'h4);
        check("R6 irq follows change-over", 8'(irq_n), 8'h0);
        wr(1'b1, 3'b011);
        rd(1'b1, d);
        check("R6 change-over cleared", 8'(d), 8'h0);
        check("R6 irq released", 8'(irq_n), 8'h1);
    endtask

    task automatic t_low_supply();
        logic [RD_W-1:0] d;
        wr(1'b0, 3'b100);
        low_cond = 1'b1;
        tick();
        rd(1'b1, d);
        check("R7 low flag follows condition", 8'(d), 8'h8);
        check("R8 irq low on low supply", 8'(irq_n), 8'h0);
        wr(1'b1, 3'b000);
        rd(1'b1, d);
        check("R7 write cannot clear low flag", 8'(d), 8'h8);
        wr(1'b0, 3'b000);
        check("R8 irq released by enable clear", 8'(irq_n), 8'h1);
        rd(1'b1, d);
        check("R8 flag kept while disabled", 8'(d), 8'h8);
        wr(1'b0, 3'b100);
        check("R8 irq low on re-enable", 8'(irq_n), 8'h0);
        low_cond = 1'b0;
        tick();
        check("R8 irq released when condition ends", 8'(irq_n), 8'h1);
        rd(1'b1, d);
        check("R7 low flag dropped", 8'(d), 8'h0);
    endtask

    task automatic t_mixed();
        wr(1'b0, 3'b111);
        cap_evt = 2'b11;
        chg_evt = 1'b1;
        tick();
        cap_evt = '0;
        chg_evt = 1'b0;
        check("R9 irq low with two sources", 8'(irq_n), 8'h0);
        wr(1'b1, 3'b100);
        check("R9 irq held by change-over", 8'(irq_n), 8'h0);
        wr(1'b1, 3'b000);
        check("R9 irq high when all clear", 8'(irq_n), 8'h1);
        wr(1'b0, 3'b000);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_readback();
        t_capture();
        t_set_wins();
        t_changeover();
        t_low_supply();
        t_mixed();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule